// File: doc/BRIEF.md
# Power-Down and Wake-Up Sequencer

This block sequences the power-down of a small microcontroller clock system. Software arms a power-down through a one-byte control register. The entry-mode bit picks when the chip goes down. With the bit clear, it goes down as soon as the arm bit is stored. With the bit set, it waits until the CPU also reports that it is sleeping on a wait-for-interrupt. While the chip is down, the crystal and fast internal oscillator enables are forced low. The PLL run output and the system clock enable are also low, so whatever clock source is selected no longer matters. The slow oscillator enable keeps following its register bit.

A wake event from a GPIO or a UART brings the chip out of power-down and clears the arm bit, so each power-down must be armed again. An optional settle delay can hold the system clock gated after wake-up. The delay is longer when the system runs from the crystal than when it runs from the fast internal oscillator. A sticky wake flag drives a level wake interrupt. Software clears the flag by writing 1 to it.

Top module: `pwrdn_wake_ctl`

## Requirements
- R1: After reset the register reads 0x07 (bit0 crystal enable, bit1 fast oscillator enable and bit2 slow oscillator enable at 1, all other bits 0), the system clock enable is 1, and the power-down and interrupt outputs are 0.
- R2: With the wait bit (bit7) at 0, a write that sets the arm bit (bit6) stores it at that clock edge, and power-down becomes active at the next edge.
- R3: With the wait bit at 1, the chip stays active while cpu_sleep is 0 and enters power-down at the first edge where the arm bit and cpu_sleep are both 1.
- R4: While powered down, the crystal enable, the fast oscillator enable, the PLL run output and the system clock enable are 0, and the slow oscillator enable equals register bit2.
- R5: A GPIO or UART wake event sampled in power-down ends the power-down at that edge and clears the arm bit.
- R6: With the delay bit (bit3) at 0, the system clock enable is 1 in the cycle after the wake edge.
- R7: With the delay bit at 1, the system clock enable stays 0 for exactly XTAL_DLY cycles (4096) from the wake edge when src_fast is 0, or FAST_DLY cycles (256) when src_fast is 1, and the count restarts from zero on every wake.
- R8: The wake flag (bit5) is set by a wake event in power-down only when the interrupt enable (bit4) is 1. A wake event outside power-down leaves the flag unchanged.
- R9: Writing 1 to bit5 clears the flag. Writing 0 to it leaves the flag unchanged. A wake event in the same cycle as a clearing write leaves the flag set.
- R10: wake_irq_o is 1 exactly while the flag and the interrupt enable are both 1.
- R11: Outside power-down, the three oscillator enables follow register bits 0 to 2 and the PLL run output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register contents |
| cpu_sleep | input | 1 | CPU is sleeping on wait-for-interrupt |
| wake_gpio | input | 1 | GPIO wake event |
| wake_uart | input | 1 | UART wake event |
| src_fast | input | 1 | System clock source: 0 crystal, 1 fast internal oscillator |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| fast_osc_en_o | output | 1 | Fast internal oscillator enable |
| slow_osc_en_o | output | 1 | Slow internal oscillator enable |
| pll_run_o | output | 1 | PLL allowed to run |
| sysclk_en_o | output | 1 | System clock gate open |
| pd_active_o | output | 1 | Chip is powered down |
| wake_irq_o | output | 1 | Level wake interrupt |

## Verification
The assertions check four rules on every cycle. Entry into power-down needs an armed register and, in wait mode, a sleeping CPU. The fast oscillators, PLL and system clock stay off while the chip is down. A wake clears the arm bit and, with no delay, reopens the clock at once. The flag only rises on a wake taken in power-down. A checker counter also bounds the closed-gate window after a wake. The bench scenarios show what those rules cannot. These are the exact settle length for each clock source, the flag surviving a clearing write in the same cycle as a wake, a write of 0 to the flag, and the interrupt level following changes to its enable.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
  localparam int CFG_W  = 8;
  localparam int F_XTAL = 0;
  localparam int F_FAST = 1;
  localparam int F_SLOW = 2;
  localparam int F_DLY  = 3;
  localparam int F_IEN  = 4;
  localparam int F_FLAG = 5;
  localparam int F_ARM  = 6;
  localparam int F_WAIT = 7;

  typedef enum logic [1:0] {
    PS_RUN    = 2'd0,
    PS_DOWN   = 2'd1,
    PS_SETTLE = 2'd2
  } pd_state_e;

  // packed MSB first: field order matches the F_* positions
  typedef struct packed {
    logic wait_cpu;
    logic arm;
    logic flag;
    logic ien;
    logic dly;
    logic slow;
    logic fast;
    logic xtal;
  } cfg_t;

  // settle length in cycles for the selected clock source
  function automatic int settle_len(input logic fast_src, input int xtal_len,
                                    input int fast_len);
    return fast_src ? fast_len : xtal_len;
  endfunction

  // power-down entry rule
  function automatic logic entry_ok(input logic arm, input logic wait_cpu,
                                    input logic sleep);
    return arm && (!wait_cpu || sleep);
  endfunction
endpackage

// File: rtl/pdw_regs.sv
module pdw_regs
  import pdw_pkg::*;
#(
  parameter logic [2:0] RST_OSC = 3'b111
) (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  cfg_t wdata,
  input  logic wake_hit,
  output cfg_t cfg,
  output logic flag_set,
  output logic flag_clr
);
  assign flag_set = wake_hit && cfg.ien;
  assign flag_clr = we && wdata.flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= cfg_t'({5'b0, RST_OSC});
    end else begin
      if (we) begin
        cfg.xtal     <= wdata.xtal;
        cfg.fast     <= wdata.fast;
        cfg.slow     <= wdata.slow;
        cfg.dly      <= wdata.dly;
        cfg.ien      <= wdata.ien;
        cfg.wait_cpu <= wdata.wait_cpu;
        cfg.arm      <= wdata.arm;
      end
      // hardware clear on wake wins over a software write
      if (wake_hit) cfg.arm <= 1'b0;
      // a wake event wins over a clearing write
      if (flag_set)      cfg.flag <= 1'b1;
      else if (flag_clr) cfg.flag <= 1'b0;
    end
  end
endmodule

// File: rtl/pdw_fsm.sv
module pdw_fsm
  import pdw_pkg::*;
#(
  parameter int XTAL_DLY = 4096,
  parameter int FAST_DLY = 256
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      arm,
  input  logic      wait_cpu,
  input  logic      cpu_sleep,
  input  logic      wake_any,
  input  logic      dly_en,
  input  logic      src_fast,
  output pd_state_e st,
  output logic      enter,
  output logic      wake_hit
);
  localparam int MAXD = (XTAL_DLY > FAST_DLY) ? XTAL_DLY : FAST_DLY;
  localparam int CW   = $clog2(MAXD + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign enter    = (st == PS_RUN) && entry_ok(arm, wait_cpu, cpu_sleep);
  assign wake_hit = (st == PS_DOWN) && wake_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= PS_RUN;
      cnt <= '0;
      lim <= '0;
    end else begin
      case (st)
        PS_RUN: if (enter) st <= PS_DOWN;
        PS_DOWN: if (wake_hit) begin
          cnt <= '0;
          lim <= CW'(settle_len(src_fast, XTAL_DLY, FAST_DLY) - 1);
          st  <= dly_en ? PS_SETTLE : PS_RUN;
        end
        PS_SETTLE: begin
          if (cnt == lim) st <= PS_RUN;
          else            cnt <= cnt + 1'b1;
        end
        default: st <= PS_RUN;
      endcase
    end
  end
endmodule

// File: rtl/pdw_osc_gate.sv
module pdw_osc_gate #(
  parameter int             N         = 3,
  parameter logic [N-1:0]   STOP_MASK = '1
) (
  input  logic [N-1:0] en_req,
  input  logic         pd,
  output logic [N-1:0] en_o
);
  for (genvar g = 0; g < N; g++) begin : g_osc
    if (STOP_MASK[g]) begin : g_stop
      assign en_o[g] = en_req[g] && !pd;
    end else begin : g_keep
      assign en_o[g] = en_req[g];
    end
  end
endmodule

// File: rtl/pwrdn_wake_ctl.sv
module pwrdn_wake_ctl
  import pdw_pkg::*;
#(
  parameter int         XTAL_DLY = 4096,
  parameter int         FAST_DLY = 256,
  parameter logic [2:0] RST_OSC  = 3'b111
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             cpu_sleep,
  input  logic             wake_gpio,
  input  logic             wake_uart,
  input  logic             src_fast,
  output logic             xtal_en_o,
  output logic             fast_osc_en_o,
  output logic             slow_osc_en_o,
  output logic             pll_run_o,
  output logic             sysclk_en_o,
  output logic             pd_active_o,
  output logic             wake_irq_o
);
  cfg_t      cfg;
  pd_state_e st;
  logic      wake_any;
  logic      wake_hit;
  logic      enter;
  logic      flag_set;
  logic      flag_clr;
  logic      pd_now;
  logic [2:0] osc_en;

  assign wake_any = wake_gpio || wake_uart;
  assign pd_now   = (st == PS_DOWN);

  pdw_regs #(.RST_OSC(RST_OSC)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_t'(cfg_wdata)),
    .wake_hit(wake_hit), .cfg(cfg), .flag_set(flag_set), .flag_clr(flag_clr)
  );

  pdw_fsm #(.XTAL_DLY(XTAL_DLY), .FAST_DLY(FAST_DLY)) u_fsm (
    .clk(clk), .rst_n(rst_n), .arm(cfg.arm), .wait_cpu(cfg.wait_cpu),
    .cpu_sleep(cpu_sleep), .wake_any(wake_any), .dly_en(cfg.dly),
    .src_fast(src_fast), .st(st), .enter(enter), .wake_hit(wake_hit)
  );

  // crystal and fast oscillator stop in power-down, slow one keeps running
  pdw_osc_gate #(.N(3), .STOP_MASK(3'b011)) u_osc (
    .en_req({cfg.slow, cfg.fast, cfg.xtal}), .pd(pd_now), .en_o(osc_en)
  );

  assign xtal_en_o     = osc_en[0];
  assign fast_osc_en_o = osc_en[1];
  assign slow_osc_en_o = osc_en[2];
  assign pll_run_o     = !pd_now;
  assign sysclk_en_o   = (st == PS_RUN);
  assign pd_active_o   = pd_now;
  assign wake_irq_o    = cfg.flag && cfg.ien;
  assign cfg_rdata     = cfg;
endmodule

// File: rtl/pdw_chk.sv
module pdw_chk
  import pdw_pkg::*;
#(
  parameter int XTAL_DLY = 4096,
  parameter int FAST_DLY = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] rdata,
  input logic             cpu_sleep,
  input logic             wake_any,
  input logic             pd,
  input logic             xtal_en,
  input logic             fast_en,
  input logic             pll_run,
  input logic             sys_en
);
  localparam int MAXD = (XTAL_DLY > FAST_DLY) ? XTAL_DLY : FAST_DLY;

  int low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             low_cnt <= 0;
    else if (!sys_en && !pd) low_cnt <= low_cnt + 1;
    else                    low_cnt <= 0;
  end

  // R2 and R3: entry needs arm and, in wait mode, a sleeping CPU
  assert_entry_rule_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd) |-> $past(rdata[F_ARM] && (!rdata[F_WAIT] || cpu_sleep)));

  assert_pd_clocks_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pd |-> (!xtal_en && !fast_en && !pll_run && !sys_en));

  assert_wake_disarms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pd && wake_any) |=> (!pd && !rdata[F_ARM]));

  assert_no_delay_reopen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pd && wake_any && !rdata[F_DLY]) |=> sys_en);

  assert_settle_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_en && !pd) |-> (low_cnt < MAXD));

  assert_flag_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdata[F_FLAG]) |-> $past(pd && wake_any && rdata[F_IEN]));
endmodule

bind pwrdn_wake_ctl pdw_chk #(.XTAL_DLY(XTAL_DLY), .FAST_DLY(FAST_DLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .rdata(cfg_rdata), .cpu_sleep(cpu_sleep),
  .wake_any(wake_any), .pd(pd_active_o), .xtal_en(xtal_en_o),
  .fast_en(fast_osc_en_o), .pll_run(pll_run_o), .sys_en(sysclk_en_o)
);

// File: tb/sim_pwrdn_wake_ctl.sv
`timescale 1ns/1ps
module sim_pwrdn_wake_ctl;
  localparam int XD = 4096;
  localparam int FD = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic cpu_sleep = 1'b0, wake_gpio = 1'b0, wake_uart = 1'b0, src_fast = 1'b0;
  logic xtal_en_o, fast_osc_en_o, slow_osc_en_o, pll_run_o, sysclk_en_o;
  logic pd_active_o, wake_irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pwrdn_wake_ctl #(.XTAL_DLY(XD), .FAST_DLY(FD)) u0 (.*);

  function automatic int exp_gap(input bit dly, input bit fast);
    if (!dly) return 0;
    return fast ? FD : XD;
  endfunction

  task automatic chk_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    tick(1);
    cfg_we = 1'b0;
  endtask

  // one armed power-down and wake; leaves the flag as the wake set it
  task automatic pd_cycle(input bit wt, input bit dly, input bit ien, input bit fast,
                          input bit uart, input int lag, input bit slow);
    int n;
    src_fast = fast;
    wr({wt, 1'b1, 1'b0, ien, dly, slow, 1'b1, 1'b1});
    if (!wt) begin
      chk_eq("R2 not yet down", pd_active_o, 0);
      tick(1);
      chk_eq("R2 down", pd_active_o, 1);
    end else begin
      repeat (lag) begin
        chk_eq("R3 waits for cpu", pd_active_o, 0);
        tick(1);
      end
      cpu_sleep = 1'b1;
      tick(1);
      cpu_sleep = 1'b0;
      chk_eq("R3 down after sleep", pd_active_o, 1);
    end
    chk_eq("R4 xtal off", xtal_en_o, 0);
    chk_eq("R4 fast off", fast_osc_en_o, 0);
    chk_eq("R4 pll off", pll_run_o, 0);
    chk_eq("R4 sysclk off", sysclk_en_o, 0);
    chk_eq("R4 slow follows", slow_osc_en_o, slow);
    tick(3);
    if (uart) wake_uart = 1'b1; else wake_gpio = 1'b1;
    tick(1);
    wake_uart = 1'b0; wake_gpio = 1'b0;
    chk_eq("R5 left pd", pd_active_o, 0);
    chk_eq("R5 arm cleared", cfg_rdata[6], 0);
    chk_eq("R8 flag", cfg_rdata[5], ien);
    chk_eq("R10 irq", wake_irq_o, ien);
    n = 0;
    while (!sysclk_en_o && n < 5000) begin
      n++;
      tick(1);
    end
    chk_eq(dly ? "R7 settle length" : "R6 immediate reopen", n, exp_gap(dly, fast));
    chk_eq("R11 xtal back", xtal_en_o, 1);
    chk_eq("R11 fast back", fast_osc_en_o, 1);
    chk_eq("R11 pll back", pll_run_o, 1);
  endtask

  task automatic clr_flag();
    wr((cfg_rdata & 8'hBF) | 8'h20);
    chk_eq("R9 cleared", cfg_rdata[5], 0);
    chk_eq("R10 irq low", wake_irq_o, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    tick(3);
    rst_n = 1'b1;
    chk_eq("R1 reg", cfg_rdata, 8'h07);
    chk_eq("R1 sysclk", sysclk_en_o, 1);
    chk_eq("R1 pd", pd_active_o, 0);
    chk_eq("R1 irq", wake_irq_o, 0);
    chk_eq("R11 slow on", slow_osc_en_o, 1);

    // wake outside power-down does nothing
    wr(8'h17);
    wake_gpio = 1'b1; tick(1); wake_gpio = 1'b0;
    chk_eq("R8 no flag when running", cfg_rdata[5], 0);
    chk_eq("R8 no irq when running", wake_irq_o, 0);

    // flag write-0, interrupt level follows enable
    pd_cycle(0, 0, 1, 0, 0, 0, 1);
    wr(cfg_rdata & 8'h9F | 8'h10);
    chk_eq("R9 write 0 keeps flag", cfg_rdata[5], 1);
    wr(cfg_rdata & 8'hCF);
    chk_eq("R10 irq off with enable", wake_irq_o, 0);
    chk_eq("R10 flag held", cfg_rdata[5], 1);
    wr((cfg_rdata & 8'hDF) | 8'h10);
    chk_eq("R10 irq back", wake_irq_o, 1);

    // wake collides with clearing write
    wr((cfg_rdata & 8'hDF) | 8'h40);
    tick(1);
    chk_eq("R2 down again", pd_active_o, 1);
    cfg_we = 1'b1; cfg_wdata = (cfg_rdata | 8'h20) & 8'hBF; wake_gpio = 1'b1;
    tick(1);
    cfg_we = 1'b0; wake_gpio = 1'b0;
    chk_eq("R9 wake beats clear", cfg_rdata[5], 1);
    chk_eq("R5 woke", pd_active_o, 0);
    clr_flag();

    // settle lengths, both sources, slow oscillator off
    pd_cycle(0, 1, 0, 0, 1, 0, 0);
    pd_cycle(1, 1, 0, 1, 0, 2, 1);
    pd_cycle(1, 1, 1, 1, 1, 0, 1);
    clr_flag();

    for (int i = 0; i < 12; i++) begin
      bit wt, dly, ien, fast, uart, slow;
      int lag;
      wt = 1'($urandom % 2); dly = 1'($urandom % 2); ien = 1'($urandom % 2);
      fast = 1'($urandom % 2); uart = 1'($urandom % 2); slow = 1'($urandom % 2);
      lag = int'($urandom % 5);
      pd_cycle(wt, dly, ien, fast, uart, lag, slow);
      if (ien) clr_flag();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule